// File: doc/BRIEF.md
# Byte-Wide Serial Port with Access-Collision Flag

This block moves one byte at a time over a four-wire synchronous serial link. It can act as the clock-driving end (master) or the clock-following end (slave). A processor reaches it through three registers: control, status and data. These registers are accessed with an address, write data, read data and separate read and write strobes. In master mode, a write to the data register loads the shift register and starts eight clock periods on the serial clock. In slave mode, the same write only stages the byte, which then goes out when the far end clocks it.

When a byte completes, the received value is copied into a one-entry receive buffer. At the same moment a transfer-done flag sets. Software clears this flag with a fixed two-step sequence: a status read that finds the flag set, then a read or write of the data register. A data-register access made while a transfer is partway through sets a collision flag. A second byte that completes before the first flag is cleared does not replace the buffered byte. A level interrupt output follows the done flag when interrupts are enabled.

Top module: `spi_xfer_port`

## Requirements
- R1: After reset, the status register (address 1) and the control register (address 0) read as 0, `irq` is low, `sck_out` is low and `sel_n_out` is high.
- R2: In master mode, a write to the data register (address 2) shifts the byte out on `ser_out`, MSB first. `ser_out` is valid at each rising `sck_out` edge, and `ser_in` is sampled on the same edge. The byte sampled on `ser_in` is later returned by a data-register read.
- R3: Control bits [3:2] pick the master clock ratio: code 0 gives 2, code 1 gives 4, code 2 gives 16 and code 3 gives 32 system clocks per serial bit. The done flag is set 8×ratio clock edges after the starting data write.
- R4: With control bit 0 (master) at 0, a data write loads the shift register, and its MSB appears on `ser_out`. It starts no transfer: `sck_out` stays low and the done flag stays 0.
- R5: In slave mode, while `sel_n_in` is low, the block samples `ser_in` on rising `sck_in` edges and advances `ser_out` on falling edges. After the eighth falling edge the done flag sets and the received byte is readable.
- R6: The done flag is status bit 7. It clears only when a data-register access follows a status read that saw it set. A data access with no such prior status read leaves it set.
- R7: A data-register read or write made after the first falling serial-clock edge of a transfer, and before the done flag sets, sets the collision flag (status bit 6). A write made in that window does not alter the byte being sent.
- R8: The collision flag clears through the same two-step sequence that clears the done flag.
- R9: If a byte completes while the done flag is still set, the receive buffer keeps the earlier byte.
- R10: `irq` is high exactly while the done flag is set and control bit 1 (interrupt enable) is 1.
- R11: Status bits 5 to 0 always read as 0, and the control register reads back its four written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for the selected register (combinational) |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| sck_out | output | 1 | Serial clock driven in master mode, idles low |
| sel_n_out | output | 1 | Active-low select, low while a master transfer runs |
| ser_out | output | 1 | Serial data out (MSB of the shift register) |
| sck_in | input | 1 | Serial clock from the far master in slave mode |
| sel_n_in | input | 1 | Active-low select from the far master in slave mode |
| ser_in | input | 1 | Serial data in |
| irq | output | 1 | Level interrupt request |

## Verification
In master mode the done flag and `irq` are registered. They appear 16×(ratio/2) clock edges after the edge that takes the data write. The bench counts falling system-clock edges from that write and requires `irq` on exactly that count for every ratio code. In slave mode, serial inputs pass through a two-stage synchronizer and an edge detector. Completion therefore lands three clock edges after the last falling `sck_in` edge, so the bench waits a fixed six clocks before sampling. Register reads are combinational and are sampled one time unit after the strobe is set up, away from the edge. Serial bits are taken by a scoreboard monitor on the rising serial-clock edge, when `ser_out` has been stable for half a bit.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

    localparam int DIV_W = 5;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_DATA = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic [1:0] rate;
        logic       irq_en;
        logic       master;
    } ctrl_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } sck_ev_t;

    // system clocks per half serial-clock period for each ratio code
    function automatic logic [DIV_W-1:0] half_period(input logic [1:0] code);
        case (code)
            2'd0:    half_period = 5'd1;
            2'd1:    half_period = 5'd2;
            2'd2:    half_period = 5'd8;
            default: half_period = 5'd16;
        endcase
    endfunction

endpackage

// File: rtl/spi_edge_src.sv
module spi_edge_src
    import spi_xfer_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       master,
    input  logic [1:0] rate,
    input  logic       start,
    input  logic       done,
    input  logic       sck_in,
    input  logic       sel_n_in,
    output logic       sck_out,
    output logic       sel_n_out,
    output logic       busy,
    output logic       slave_act,
    output sck_ev_t    ev
);
    logic [DIV_W-1:0]     div_q;
    logic                 sck_q;
    logic                 run_q;
    logic                 tick;
    logic [SYNC_STAGES:0] sck_sync;
    logic [SYNC_STAGES-1:0] sel_sync;
    sck_ev_t              m_ev, s_ev;

    assign tick = run_q && (div_q == half_period(rate) - 5'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            sck_q <= 1'b0;
            run_q <= 1'b0;
        end else if (start) begin
            div_q <= '0;
            sck_q <= 1'b0;
            run_q <= 1'b1;
        end else if (run_q) begin
            if (tick) begin
                div_q <= '0;
                sck_q <= ~sck_q;
            end else begin
                div_q <= div_q + 5'd1;
            end
            if (done) run_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_sync <= '0;
            sel_sync <= '1;
        end else begin
            sck_sync <= {sck_sync[SYNC_STAGES-1:0], sck_in};
            sel_sync <= {sel_sync[SYNC_STAGES-2:0], sel_n_in};
        end
    end

    assign slave_act = ~sel_sync[SYNC_STAGES-1];
    assign m_ev.rise = tick && !sck_q;
    assign m_ev.fall = tick && sck_q;
    assign s_ev.rise = slave_act && sck_sync[SYNC_STAGES-1] && !sck_sync[SYNC_STAGES];
    assign s_ev.fall = slave_act && !sck_sync[SYNC_STAGES-1] && sck_sync[SYNC_STAGES];

    assign ev        = master ? m_ev : s_ev;
    assign busy      = run_q;
    assign sck_out   = sck_q;
    assign sel_n_out = master ? ~run_q : 1'b1;
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
    import spi_xfer_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  sck_ev_t           ev,
    input  logic              ser_in,
    output logic              ser_out,
    output logic              window,
    output logic              done,
    output logic [DATA_W-1:0] rx_byte
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    logic [DATA_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              samp_q;
    logic              seen_q;

    assign done    = ev.fall && (cnt_q == LAST);
    assign rx_byte = {sh_q[DATA_W-2:0], samp_q};
    assign ser_out = sh_q[DATA_W-1];
    assign window  = seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            cnt_q  <= '0;
            samp_q <= 1'b0;
            seen_q <= 1'b0;
        end else begin
            if (ev.rise) samp_q <= ser_in;
            if (load) begin
                sh_q <= load_val;
            end else if (ev.fall) begin
                sh_q <= rx_byte;
            end
            if (clr) begin
                cnt_q  <= '0;
                seen_q <= 1'b0;
            end else if (ev.fall) begin
                if (cnt_q == LAST) begin
                    cnt_q  <= '0;
                    seen_q <= 1'b0;
                end else begin
                    cnt_q  <= cnt_q + 1'b1;
                    seen_q <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spi_flags.sv
module spi_flags #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stat_rd,
    input  logic              data_acc,
    input  logic              window,
    input  logic              done,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              tc,
    output logic              coll,
    output logic              armed,
    output logic [DATA_W-1:0] rxbuf
);
    logic clear;

    assign clear = armed && data_acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            tc    <= 1'b0;
            coll  <= 1'b0;
            armed <= 1'b0;
            rxbuf <= '0;
        end else begin
            if (data_acc)          armed <= 1'b0;
            else if (stat_rd && tc) armed <= 1'b1;

            if (done)       tc <= 1'b1;
            else if (clear) tc <= 1'b0;

            if (data_acc && window) coll <= 1'b1;
            else if (clear)         coll <= 1'b0;

            // overrun: a set flag protects the byte already buffered
            if (done && !tc) rxbuf <= rx_byte;
        end
    end
endmodule

// File: rtl/spi_xfer_port.sv
module spi_xfer_port
    import spi_xfer_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              reg_rd,
    input  logic              reg_wr,
    output logic              sck_out,
    output logic              sel_n_out,
    output logic              ser_out,
    input  logic              sck_in,
    input  logic              sel_n_in,
    input  logic              ser_in,
    output logic              irq
);
    localparam int CTRL_W = $bits(ctrl_t);

    ctrl_t             ctrl_q;
    sck_ev_t           ev;
    logic              busy, slave_act, window, done;
    logic              tc, coll, armed;
    logic              data_acc, stat_rd, data_wr, start, load, clr;
    logic [DATA_W-1:0] rx_byte, rxbuf;

    assign data_acc = (reg_rd || reg_wr) && (reg_addr == REG_DATA);
    assign data_wr  = reg_wr && (reg_addr == REG_DATA);
    assign stat_rd  = reg_rd && (reg_addr == REG_STAT);
    assign start    = data_wr && ctrl_q.master && !busy;
    assign load     = data_wr && !window;
    assign clr      = start || (!ctrl_q.master && !slave_act);

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else if (reg_wr && reg_addr == REG_CTRL) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_CTRL: reg_rdata[CTRL_W-1:0] = ctrl_q;
            REG_STAT: begin
                reg_rdata[DATA_W-1] = tc;
                reg_rdata[DATA_W-2] = coll;
            end
            REG_DATA: reg_rdata = rxbuf;
            default:  reg_rdata = '0;
        endcase
    end

    assign irq = tc && ctrl_q.irq_en;

    spi_edge_src #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst(rst), .master(ctrl_q.master), .rate(ctrl_q.rate),
        .start(start), .done(done), .sck_in(sck_in), .sel_n_in(sel_n_in),
        .sck_out(sck_out), .sel_n_out(sel_n_out), .busy(busy),
        .slave_act(slave_act), .ev(ev)
    );

    spi_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst(rst), .clr(clr), .load(load), .load_val(reg_wdata),
        .ev(ev), .ser_in(ser_in), .ser_out(ser_out), .window(window),
        .done(done), .rx_byte(rx_byte)
    );

    spi_flags #(.DATA_W(DATA_W)) u_flags (
        .clk(clk), .rst(rst), .stat_rd(stat_rd), .data_acc(data_acc),
        .window(window), .done(done), .rx_byte(rx_byte), .tc(tc),
        .coll(coll), .armed(armed), .rxbuf(rxbuf)
    );
endmodule

// File: rtl/spi_xfer_port_chk.sv
module spi_xfer_port_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              master,
    input logic              busy,
    input logic              sck_out,
    input logic              tc,
    input logic              coll,
    input logic              armed,
    input logic              data_acc,
    input logic              window,
    input logic              done,
    input logic              irq,
    input logic [DATA_W-1:0] rxbuf
);
    a_r2_done_sets_flag: assert property (@(posedge clk) disable iff (rst)
        done |=> tc);

    a_r3_sck_idle_low: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sck_out);

    a_r4_slave_no_start: assert property (@(posedge clk) disable iff (rst)
        (!master && !busy) |=> !busy);

    a_r6_flag_holds: assert property (@(posedge clk) disable iff (rst)
        (tc && !(armed && data_acc)) |=> tc);

    a_r6_flag_clears: assert property (@(posedge clk) disable iff (rst)
        (armed && data_acc && !done) |=> !tc);

    a_r7_coll_sets: assert property (@(posedge clk) disable iff (rst)
        (window && data_acc) |=> coll);

    a_r9_overrun_keeps: assert property (@(posedge clk) disable iff (rst)
        (tc && done) |=> $stable(rxbuf));

    a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        irq |-> tc);
endmodule

bind spi_xfer_port spi_xfer_port_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .master(ctrl_q.master), .busy(busy),
    .sck_out(sck_out), .tc(tc), .coll(coll), .armed(armed),
    .data_acc(data_acc), .window(window), .done(done), .irq(irq),
    .rxbuf(rxbuf)
);

// File: tb/spi_xfer_port_bench.sv
module spi_xfer_port_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HB = 6; // slave-mode half bit in clocks

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       reg_rd = 1'b0, reg_wr = 1'b0;
    logic       sck_out, sel_n_out, ser_out, irq;
    logic       sck_in = 1'b0, sel_n_in = 1'b1, ser_in;
    logic       tb_slave = 1'b0, sl_bit = 1'b0;
    logic [7:0] ms_pat = 8'd0;

    int n_chk = 0, n_fail = 0, sck_edges = 0, bit_n = 0;
    logic [7:0] got = 8'd0;
    logic [7:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign ser_in = tb_slave ? sl_bit : ms_pat[7];

    spi_xfer_port u_spi_xfer_port (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .sck_out(sck_out), .sel_n_out(sel_n_out), .ser_out(ser_out),
        .sck_in(sck_in), .sel_n_in(sel_n_in), .ser_in(ser_in), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor: one bit per rising serial clock
    task automatic take_bit();
        got = {got[6:0], ser_out};
        bit_n++;
        if (bit_n == 8) begin
            bit_n = 0;
            if (exp_q.size() == 0) check(1'b0, "R2 unexpected byte", got, 0);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(got == e, "R2/R5/R7 shifted-out byte", got, e);
            end
        end
    endtask

    // far-end slave model for master mode: advances on falling sck_out
    always @(negedge sck_out) ms_pat <= {ms_pat[6:0], 1'b0};
    always @(posedge sck_out) begin
        sck_edges++;
        take_bit();
    end
    always @(posedge sck_in) take_bit();

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // driver: push expectation, start the byte, count clocks to irq
    task automatic master_xfer(input logic [7:0] tx, input logic [7:0] far, output int n);
        exp_q.push_back(tx);
        ms_pat = far;
        wr(2'd2, tx);
        n = 0;
        while (!irq && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic clear_seq(output logic [7:0] d);
        logic [7:0] s;
        rd(2'd1, s);
        rd(2'd2, d);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        check(1'b0, "watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1
        rd(2'd1, d); check(d == 8'h00, "R1 status after reset", d, 0);
        rd(2'd0, d); check(d == 8'h00, "R1 control after reset", d, 0);
        check(!irq && !sck_out && sel_n_out, "R1 pins after reset",
              {irq, sck_out, sel_n_out}, 3'b001);

        // R3 / R2: every ratio code, master, irq enabled
        for (int c = 0; c < 4; c++) begin
            int ratio;
            logic [7:0] tx, far;
            ratio = (c == 0) ? 2 : (c == 1) ? 4 : (c == 2) ? 16 : 32;
            tx  = 8'hA1 + 8'(c * 37);
            far = 8'h5C ^ 8'(c * 19);
            wr(2'd0, {4'd0, 2'(c), 2'b11});
            rd(2'd0, d); check(d == {4'd0, 2'(c), 2'b11}, "R11 control readback", d, {4'd0, 2'(c), 2'b11});
            master_xfer(tx, far, n);
            check(n == 8 * ratio, "R3 done delay", n, 8 * ratio);
            rd(2'd1, d); check(d == 8'h80, "R11 status done only", d, 8'h80);
            rd(2'd2, d); check(d == far, "R2 received byte", d, far);
            idle(2);
            check(!irq, "R6 flag cleared by sequence", irq, 0);
        end

        // R6: data access without prior status read leaves flag
        wr(2'd0, 8'h03);
        master_xfer(8'h3E, 8'hE3, n);
        rd(2'd2, d);
        idle(2);
        check(irq, "R6 flag kept without status read", irq, 1);

        // R9: second byte completes while flag still set
        exp_q.push_back(8'h77);
        ms_pat = 8'h19;
        wr(2'd2, 8'h77);
        idle(24);
        rd(2'd2, d); check(d == 8'hE3, "R9 buffer keeps first byte", d, 8'hE3);
        clear_seq(d);
        idle(1);
        check(!irq, "R6 cleared after overrun", irq, 0);

        // R7 / R8: collision at ratio 16
        wr(2'd0, 8'h0B);
        exp_q.push_back(8'hC3);
        ms_pat = 8'h81;
        wr(2'd2, 8'hC3);
        idle(30);
        rd(2'd2, d);
        wr(2'd2, 8'hFF);
        n = 0;
        while (!irq && n < 2000) begin @(negedge clk); n++; end
        rd(2'd1, d); check(d == 8'hC0, "R7 collision flag set", d, 8'hC0);
        rd(2'd2, d); check(d == 8'h81, "R7 received byte intact", d, 8'h81);
        rd(2'd1, d); check(d == 8'h00, "R8 collision cleared", d, 0);

        // R10: interrupt disabled
        wr(2'd0, 8'h01);
        exp_q.push_back(8'h42);
        ms_pat = 8'h24;
        wr(2'd2, 8'h42);
        idle(20);
        check(!irq, "R10 irq masked", irq, 0);
        rd(2'd1, d); check(d == 8'h80, "R10 flag still set", d, 8'h80);
        rd(2'd2, d);

        // R4: slave write stages only
        wr(2'd0, 8'h02);
        n = sck_edges;
        wr(2'd2, 8'hA5);
        idle(40);
        check(sck_edges == n, "R4 no serial clock", sck_edges, n);
        check(!irq && ser_out, "R4 staged MSB, no done", {irq, ser_out}, 2'b01);
        check(sel_n_out, "R4 select idle", sel_n_out, 1);

        // R5: far master clocks a byte in
        tb_slave = 1'b1;
        exp_q.push_back(8'hA5);
        begin
            logic [7:0] p;
            p = 8'h3C;
            sel_n_in = 1'b0;
            sl_bit = p[7];
            idle(HB);
            for (int b = 0; b < 8; b++) begin
                sck_in = 1'b1;
                idle(HB);
                sck_in = 1'b0;
                p = {p[6:0], 1'b0};
                sl_bit = p[7];
                idle(HB);
            end
            sel_n_in = 1'b1;
        end
        check(irq, "R5 slave done", irq, 1);
        rd(2'd1, d); check(d == 8'h80, "R5 slave status", d, 8'h80);
        rd(2'd2, d); check(d == 8'h3C, "R5 slave received", d, 8'h3C);
        check(exp_q.size() == 0, "R2 all bytes seen", exp_q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule